// File: doc/BRIEF.md
# Physical Memory Protection Region Checker

This block decides whether one memory access is permitted under a set of protection regions. Each region has a configuration byte and a 30-bit word address. The configuration byte holds read, write and execute permissions, an address-matching mode and a lock bit. The caller also supplies the 32-bit byte address of the access, what kind of access it is (load, store or instruction fetch) and whether the hart runs at user or machine privilege. The block returns one fault flag. It has no clock and no state: the flag is a pure function of the present inputs. All region settings arrive on flat input vectors.

Two address-matching modes are supported: an exact 4-byte word, and a naturally aligned power-of-two block. A grain parameter sets the smallest block size. When the grain is above zero, the single-word mode is not available. When the grain is above one, the low address bits of a block region are forced to ones. The lowest-numbered region that covers the address decides the outcome on its own. Fixed high-numbered regions can therefore be overridden by lower ones.

Top module: `pmpchk_top`

## Requirements
- R1: A region's 30-bit address holds a byte address shifted right by two. Matching uses access address bits 31:2 only, so byte offset bits 1:0 never change the result.
- R2: A power-of-two region whose effective address ends in k one-bits covers 2^(k+3) bytes. Matching compares every address bit above those k ones and the zero that follows them. An all-ones address covers the whole 4 GiB space.
- R3: The configuration byte layout is: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode, bit 7 lock. Mode values are 0 off, 1 top-of-range, 2 single word and 3 power-of-two. Mode 1 matches nothing, exactly as off does. Bits 6:5 have no effect.
- R4: With GRAIN = 0, mode 2 matches exactly the one word whose address equals the region address. With GRAIN > 0, mode 2 matches nothing.
- R5: With GRAIN > 1, the low GRAIN-1 bits of a power-of-two region's address are treated as ones, whatever is stored in them. The smallest region is then 1 << (GRAIN+2) bytes.
- R6: When several regions match, only the lowest-numbered one decides the outcome.
- R7: The access kind code is 0 load, 1 store, 2 fetch and 3 reserved. A code selects the read, write or execute bit of the deciding region. The reserved code is granted by no region.
- R8: A user-mode access that no region matches faults.
- R9: For a machine-mode access, the deciding region is enforced only when its lock bit is set. An unlocked deciding region allows the access.
- R10: A machine-mode access that no region matches is allowed. With NREG = 0, machine mode never faults and user mode always faults.
- R11: The fault output follows its inputs combinationally, with no clock edge between a change of input and the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_flat | input | 8*max(NREG,1) | Configuration bytes, region i at bits [8i+7:8i] |
| addr_flat | input | 30*max(NREG,1) | Region word addresses, region i at bits [30i+29:30i] |
| acc_addr | input | 32 | Byte address of the access |
| acc_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| priv_u | input | 1 | 1 for user mode, 0 for machine mode |
| fault | output | 1 | 1 when the access is denied |

## Verification
The case that matters is when address matching and priority resolution act together. Two regions cover the same address: a small unlocked lower region with narrow permissions, and a large locked upper region that grants everything. The bench sets up this overlap and issues the same address in both privilege modes. The result is judged against the lower region alone, so the flag must change with privilege and permission even though the upper region would allow the access. Boundary words just inside and just outside each region show whether the mask and the priority meet at the correct word.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;

  localparam int WORD_W = 30;
  localparam int CFG_W  = 8;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       exec;
    logic       wr;
    logic       rd;
  } cfgb_t;

  // Mask with the low (g-1) bits set; zero when g <= 1.
  function automatic logic [WORD_W-1:0] grain_ones(input int g);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < g - 1) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pmpchk_region.sv
module pmpchk_region
  import pmpchk_pkg::*;
#(
  parameter int GRAIN = 0
) (
  input  logic [CFG_W-1:0]  cfg_raw,
  input  logic [WORD_W-1:0] reg_word,
  input  logic [WORD_W-1:0] acc_word,
  input  logic [1:0]        kind_raw,
  input  logic              priv_u,
  output logic              hit,
  output logic              deny
);

  localparam logic [WORD_W-1:0] FORCE_ONES = grain_ones(GRAIN);

  cfgb_t             cfg;
  acc_e              kind;
  logic [WORD_W-1:0] eff_word;
  logic [WORD_W-1:0] span;
  logic              napot_hit;
  logic              na4_hit;
  logic              perm;
  logic              enforced;
  logic              unused_rsvd;

  assign cfg         = cfgb_t'(cfg_raw);
  assign kind        = acc_e'(kind_raw);
  assign unused_rsvd = ^cfg.rsvd;

  // Grain forces low ones, so the span never shrinks below the minimum size.
  assign eff_word  = reg_word | FORCE_ONES;
  // Bits covering the trailing ones and the zero that ends them.
  assign span      = eff_word ^ (eff_word + {{(WORD_W-1){1'b0}}, 1'b1});
  assign napot_hit = ((acc_word ^ eff_word) & ~span) == '0;

  generate
    if (GRAIN == 0) begin : g_na4
      assign na4_hit = (acc_word == reg_word);
    end else begin : g_no_na4
      assign na4_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (cfg.mode)
      AM_NAPOT: hit = napot_hit;
      AM_NA4:   hit = na4_hit;
      default:  hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (kind)
      ACC_LOAD:  perm = cfg.rd;
      ACC_STORE: perm = cfg.wr;
      ACC_FETCH: perm = cfg.exec;
      default:   perm = 1'b0;
    endcase
  end

  assign enforced = priv_u | cfg.lock;
  assign deny     = enforced & ~perm;

endmodule

// File: rtl/pmpchk_prio.sv
module pmpchk_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] hit,
  input  logic [N-1:0] deny,
  output logic         any_hit,
  output logic         pick_deny
);

  assign any_hit = |hit;

  // Walk from the top down so the lowest index is written last and wins.
  always_comb begin
    pick_deny = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) pick_deny = deny[i];
    end
  end

endmodule

// File: rtl/pmpchk_top.sv
module pmpchk_top
  import pmpchk_pkg::*;
#(
  parameter  int NREG  = 4,
  parameter  int GRAIN = 0,
  localparam int NSLOT = (NREG > 0) ? NREG : 1
) (
  input  logic [CFG_W*NSLOT-1:0]  cfg_flat,
  input  logic [WORD_W*NSLOT-1:0] addr_flat,
  input  logic [31:0]             acc_addr,
  input  logic [1:0]              acc_kind,
  input  logic                    priv_u,
  output logic                    fault
);

  logic [NSLOT-1:0]  hit_vec;
  logic [NSLOT-1:0]  deny_vec;
  logic [WORD_W-1:0] acc_word;
  logic              unused_lsb;

  assign acc_word   = acc_addr[31:2];
  assign unused_lsb = ^acc_addr[1:0];

  generate
    if (NREG == 0) begin : g_empty
      logic unused_in;
      assign unused_in = ^{cfg_flat, addr_flat, acc_word, acc_kind};
      assign hit_vec   = '0;
      assign deny_vec  = '0;
      assign fault     = priv_u;
    end else begin : g_regions
      logic any_hit;
      logic pick_deny;

      for (genvar r = 0; r < NREG; r++) begin : g_rgn
        pmpchk_region #(
          .GRAIN (GRAIN)
        ) u_region (
          .cfg_raw  (cfg_flat[CFG_W*r +: CFG_W]),
          .reg_word (addr_flat[WORD_W*r +: WORD_W]),
          .acc_word (acc_word),
          .kind_raw (acc_kind),
          .priv_u   (priv_u),
          .hit      (hit_vec[r]),
          .deny     (deny_vec[r])
        );
      end

      pmpchk_prio #(
        .N (NREG)
      ) u_prio (
        .hit       (hit_vec),
        .deny      (deny_vec),
        .any_hit   (any_hit),
        .pick_deny (pick_deny)
      );

      assign fault = any_hit ? pick_deny : priv_u;
    end
  endgenerate

endmodule

// File: rtl/pmpchk_check.sv
module pmpchk_check
  import pmpchk_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int GRAIN = 0,
  parameter int NSLOT = 4
) (
  input logic [CFG_W*NSLOT-1:0] cfg_flat,
  input logic [1:0]             acc_kind,
  input logic                   priv_u,
  input logic [NSLOT-1:0]       hit_vec,
  input logic                   fault
);

  logic any_lock;
  logic any_live;

  always_comb begin
    any_lock = 1'b0;
    any_live = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (cfg_flat[CFG_W*i + 7]) any_lock = 1'b1;
      if (cfg_flat[CFG_W*i + 4 -: 2] == 2'd3) any_live = 1'b1;
      if (cfg_flat[CFG_W*i + 4 -: 2] == 2'd2 && GRAIN == 0) any_live = 1'b1;
    end
  end

  always_comb begin
    if (!priv_u && !any_lock) begin
      assert_m_unlocked_R9: assert (!fault)
        else $error("machine access faulted with no locked region");
    end
    if (priv_u && !any_live) begin
      assert_u_nomatch_R8: assert (fault)
        else $error("user access allowed with no live region");
    end
    if (priv_u && acc_kind == 2'd3) begin
      assert_rsvd_kind_R7: assert (fault)
        else $error("reserved access kind granted in user mode");
    end
  end

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_chk
      always_comb begin
        if (cfg_flat[CFG_W*r + 4 -: 2] == 2'd1) begin
          assert_tor_off_R3: assert (!hit_vec[r])
            else $error("top-of-range region %0d matched", r);
        end
        if (GRAIN > 0 && cfg_flat[CFG_W*r + 4 -: 2] == 2'd2) begin
          assert_na4_off_R4: assert (!hit_vec[r])
            else $error("single-word region %0d matched with grain above zero", r);
        end
      end
    end
  endgenerate

endmodule

bind pmpchk_top pmpchk_check #(
  .NREG  (NREG),
  .GRAIN (GRAIN),
  .NSLOT (NSLOT)
) u_pmpchk_check (
  .cfg_flat (cfg_flat),
  .acc_kind (acc_kind),
  .priv_u   (priv_u),
  .hit_vec  (hit_vec),
  .fault    (fault)
);

// File: tb/test_pmpchk_top.sv
module test_pmpchk_top;

  typedef struct packed {
    logic [1:0]   sel;   // 0: NREG=4 GRAIN=3, 1: NREG=2 GRAIN=0, 2: NREG=0
    logic [31:0]  cfg;
    logic [119:0] adr;
    logic [31:0]  acc;
    logic [1:0]   kind;
    logic         u;
    logic         exp;
    logic [7:0]   req;
  } vec_t;

  localparam logic [31:0]  CFG_A = {8'h8F, 8'h17, 8'h9F, 8'h19};
  localparam logic [119:0] ADR_A = {30'h9000, 30'h8000, 30'h1FFF, 30'h41F};
  localparam logic [31:0]  CFG_B = {24'h0, 8'hF9};
  localparam logic [119:0] ADR_B = {90'h0, 30'h400};
  localparam logic [31:0]  CFG_C = {24'h0, 8'h1F};
  localparam logic [119:0] ADR_C = {90'h0, 30'h3FFFFFFF};
  localparam logic [31:0]  CFG_F = {16'h0, 8'h1B, 8'h11};
  localparam logic [119:0] ADR_F = {60'h0, 30'h400, 30'h8000};

  localparam int NVEC = 28;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, CFG_A, ADR_A, 32'h0000_1000, 2'd0, 1'b1, 1'b0, 8'd7},  // R7 read granted
    '{2'd0, CFG_A, ADR_A, 32'h0000_1010, 2'd1, 1'b1, 1'b1, 8'd6},  // R6 lower region wins
    '{2'd0, CFG_A, ADR_A, 32'h0000_1010, 2'd1, 1'b0, 1'b0, 8'd9},  // R9 unlocked in M
    '{2'd0, CFG_A, ADR_A, 32'h0000_2000, 2'd1, 1'b1, 1'b0, 8'd2},  // R2 large region
    '{2'd0, CFG_A, ADR_A, 32'h0000_2000, 2'd2, 1'b0, 1'b0, 8'd9},  // R9 locked, X set
    '{2'd0, CFG_A, ADR_A, 32'h0002_0000, 2'd0, 1'b1, 1'b1, 8'd4},  // R4 single word off
    '{2'd0, CFG_A, ADR_A, 32'h0002_4000, 2'd0, 1'b1, 1'b1, 8'd3},  // R3 TOR is off
    '{2'd0, CFG_A, ADR_A, 32'h0002_0000, 2'd0, 1'b0, 1'b0, 8'd10}, // R10 M no match
    '{2'd0, CFG_A, ADR_A, 32'h0000_10FC, 2'd1, 1'b1, 1'b1, 8'd2},  // R2 last word
    '{2'd0, CFG_A, ADR_A, 32'h0000_1100, 2'd1, 1'b1, 1'b0, 8'd6},  // R6 past lower
    '{2'd0, CFG_A, ADR_A, 32'h0001_0000, 2'd0, 1'b1, 1'b1, 8'd8},  // R8 past upper
    '{2'd0, CFG_A, ADR_A, 32'h0000_FFFC, 2'd2, 1'b1, 1'b0, 8'd2},  // R2 upper last
    '{2'd0, CFG_B, ADR_B, 32'h0000_101C, 2'd0, 1'b1, 1'b0, 8'd5},  // R5 forced ones
    '{2'd0, CFG_B, ADR_B, 32'h0000_1020, 2'd0, 1'b1, 1'b1, 8'd5},  // R5 end of grain
    '{2'd0, CFG_B, ADR_B, 32'h0000_1004, 2'd1, 1'b0, 1'b1, 8'd9},  // R9 lock enforced
    '{2'd0, CFG_B, ADR_B, 32'h0000_1020, 2'd1, 1'b0, 1'b0, 8'd10}, // R10 M no match
    '{2'd0, CFG_B, ADR_B, 32'h0000_1000, 2'd3, 1'b0, 1'b1, 8'd7},  // R7 reserved kind
    '{2'd0, CFG_B, ADR_B, 32'h0000_1003, 2'd0, 1'b1, 1'b0, 8'd1},  // R1 byte offset
    '{2'd0, CFG_B, ADR_B, 32'h0000_1008, 2'd0, 1'b1, 1'b0, 8'd3},  // R3 bits 6:5 set
    '{2'd0, CFG_C, ADR_C, 32'hFFFF_FFFC, 2'd1, 1'b1, 1'b0, 8'd2},  // R2 whole space
    '{2'd0, CFG_C, ADR_C, 32'h0000_0000, 2'd2, 1'b1, 1'b0, 8'd2},  // R2 whole space
    '{2'd1, CFG_F, ADR_F, 32'h0002_0000, 2'd0, 1'b1, 1'b0, 8'd4},  // R4 single word hit
    '{2'd1, CFG_F, ADR_F, 32'h0002_0004, 2'd0, 1'b1, 1'b1, 8'd4},  // R4 next word
    '{2'd1, CFG_F, ADR_F, 32'h0002_0000, 2'd1, 1'b1, 1'b1, 8'd7},  // R7 W clear
    '{2'd1, CFG_F, ADR_F, 32'h0000_1004, 2'd1, 1'b1, 1'b0, 8'd2},  // R2 8-byte block
    '{2'd1, CFG_F, ADR_F, 32'h0000_1008, 2'd1, 1'b1, 1'b1, 8'd2},  // R2 past block
    '{2'd2, 32'h0,  120'h0, 32'h0000_1000, 2'd1, 1'b0, 1'b0, 8'd10}, // R10 empty M
    '{2'd2, 32'h0,  120'h0, 32'h0000_1000, 2'd0, 1'b1, 1'b1, 8'd10}  // R10 empty U
  };

  logic         clk;
  logic         rst_n;
  logic [31:0]  cfg_in;
  logic [119:0] adr_in;
  logic [31:0]  acc_in;
  logic [1:0]   kind_in;
  logic         u_in;
  logic         fault_main;
  logic         fault_fine;
  logic         fault_none;

  int checks;
  int misses;
  bit done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  pmpchk_top #(.NREG(4), .GRAIN(3)) i_pmpchk_top (
    .cfg_flat  (cfg_in),
    .addr_flat (adr_in),
    .acc_addr  (acc_in),
    .acc_kind  (kind_in),
    .priv_u    (u_in),
    .fault     (fault_main)
  );

  pmpchk_top #(.NREG(2), .GRAIN(0)) i_pmpchk_top_fine (
    .cfg_flat  (cfg_in[15:0]),
    .addr_flat (adr_in[59:0]),
    .acc_addr  (acc_in),
    .acc_kind  (kind_in),
    .priv_u    (u_in),
    .fault     (fault_fine)
  );

  pmpchk_top #(.NREG(0), .GRAIN(0)) i_pmpchk_top_none (
    .cfg_flat  (cfg_in[7:0]),
    .addr_flat (adr_in[29:0]),
    .acc_addr  (acc_in),
    .acc_kind  (kind_in),
    .priv_u    (u_in),
    .fault     (fault_none)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: fault=%0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic logic pick(input logic [1:0] s);
    return (s == 2'd0) ? fault_main : (s == 2'd1) ? fault_fine : fault_none;
  endfunction

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        misses++;
        checks++;
        $display("FAIL watchdog: run still busy at cycle %0d expected end", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
        $finish;
      end
    end
  end

  initial begin
    checks  = 0;
    misses  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    cfg_in  = '0;
    adr_in  = '0;
    acc_in  = '0;
    kind_in = 2'd0;
    u_in    = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state, all regions off: R8 user faults, R10 machine allowed.
    check(fault_main, 1'b1, "R8 reset state user");
    u_in = 1'b0;
    #2;
    check(fault_main, 1'b0, "R10 reset state machine");
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      cfg_in  = VECS[k].cfg;
      adr_in  = VECS[k].adr;
      acc_in  = VECS[k].acc;
      kind_in = VECS[k].kind;
      u_in    = VECS[k].u;
      #3;
      check(pick(VECS[k].sel), VECS[k].exp,
            $sformatf("R%0d vector %0d", VECS[k].req, k));
    end

    // R11: result follows an address change with no clock edge in between.
    @(posedge clk);
    #2;
    cfg_in  = CFG_A;
    adr_in  = ADR_A;
    kind_in = 2'd1;
    u_in    = 1'b1;
    acc_in  = 32'h0000_1010;
    #1;
    check(fault_main, 1'b1, "R11 combinational before edge");
    acc_in = 32'h0000_2000;
    #1;
    check(fault_main, 1'b0, "R11 combinational update");

    // R6: lower region masks a locked permissive upper region, both privileges.
    acc_in = 32'h0000_1040;
    kind_in = 2'd2;
    #1;
    check(fault_main, 1'b1, "R6 overlap user fetch");
    u_in = 1'b0;
    #1;
    check(fault_main, 1'b0, "R6 overlap machine fetch");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

endmodule